// File: doc/BRIEF.md
# Processor Operating Mode Tracker

This block watches register writes that a processor core issues to its mode-related control state and keeps the architectural mode view current. The writes target the main control register, the page-table base register, the paging-extensions control register, the extended feature register, the code segment attribute register, the flags register and four segment base registers. From these it derives the operating mode (legacy or long), the submode (real, protected, virtual-8086, compatibility or 64-bit) and the current privilege level. It also raises one-cycle flush requests toward the instruction and data translation caches.

The block also holds a stored base and an effective base for the ES, CS, SS and DS segments. In 64-bit operation these four segments act as flat, so their effective bases read zero. They take the stored bases again once the code segment leaves 64-bit form.

Writes enter through a valid/ready port. `wr_ready` is held high, so the block never applies back-pressure: every cycle with `wr_valid` high commits one write at that clock edge. All outputs are registered or decoded from registered state, and they show the effect of a write in the cycle after the edge that accepted it.

Top module: `mode_tracker`

## Requirements
- R1: After reset the control value reads 0x10, the mode is legacy (`mode_long`=0), the submode is real (code 0), `cpl` is 0, both flush outputs are low and all effective bases are zero.
- R2: A write to the main control register (select 0) stores the data with bit 4 forced to one.
- R3: When a main-control write flips bit 31 (paging) while the feature register's long-enable bit (bit 8) is set, `mode_long` takes the new bit 31. If long-enable is clear, the mode does not change.
- R4: In long mode the submode is 64-bit (code 4) when the code segment attribute's long bit (bit 9) is set, and compatibility (code 3) when it is clear.
- R5: In legacy mode the submode is real (code 0) when main-control bit 0 is clear. When bit 0 is set, it is virtual-8086 (code 2) if flags bit 17 is set, and protected (code 1) if flags bit 17 is clear.
- R6: A main-control write that flips bit 31 raises `flush_all` for exactly the one cycle after the write. A write that leaves bit 31 unchanged raises nothing.
- R7: Any write to the page-table base register (select 1) raises `flush_nonglobal` for exactly the one cycle after the write.
- R8: A write to the paging-extensions register (select 2) that flips bit 4, 5 or 7 raises `flush_all` for one cycle. A write that flips only other bits raises no flush.
- R9: When a code segment attribute write (select 4) sets the long bit, all four effective bases become zero. When such a write clears the long bit, each effective base is reloaded from its stored base.
- R10: A base write (select 6..9 for ES, CS, SS, DS) always updates the stored base. It updates the effective base only when the block is not in 64-bit submode.
- R11: `cpl` equals bits 6:5 of the most recent code segment attribute write.
- R12: The long-active state is owned by the hardware. A feature register write (select 3) changes only long-enable, and setting bit 10 in the written data leaves `mode_long` unchanged. Writes with an unused select (10..15) change nothing.
- R13: `wr_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_sel | input | 4 | Target register select |
| wr_data | input | DW | Write data |
| mode_long | output | 1 | 1 = long mode, 0 = legacy mode |
| submode | output | 3 | 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| cpl | output | 2 | Current privilege level |
| ctl0_value | output | DW | Stored main control register |
| eff_base | output | 4*AW | Effective bases: ES in the low AW bits, then CS, SS, DS |
| flush_all | output | 1 | Full translation-cache flush pulse |
| flush_nonglobal | output | 1 | Non-global translation-cache flush pulse |

## Verification
A single main-control write that flips paging while long-enable is set changes the mode, changes the submode and raises `flush_all`, all in the same output cycle. The bench issues this write in both directions, with the code segment long bit clear and again with it set. It checks the mode, the submode and the pulse together against a reference model. A code segment attribute write that switches to 64-bit form moves the submode, the privilege level and all four effective bases in one cycle. Each of those outputs is compared in that same sample.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned NSEG = 4;

  typedef enum logic [3:0] {
    SEL_CTL0  = 4'd0,
    SEL_CTL3  = 4'd1,
    SEL_CTL4  = 4'd2,
    SEL_FEAT  = 4'd3,
    SEL_CSATR = 4'd4,
    SEL_FLAGS = 4'd5,
    SEL_ES    = 4'd6,
    SEL_CSB   = 4'd7,
    SEL_SS    = 4'd8,
    SEL_DS    = 4'd9
  } reg_sel_e;

  typedef enum logic [2:0] {
    SM_REAL   = 3'd0,
    SM_PROT   = 3'd1,
    SM_V86    = 3'd2,
    SM_COMPAT = 3'd3,
    SM_64     = 3'd4
  } submode_e;

  // bit positions inside written data
  localparam int unsigned C0_PE   = 0;
  localparam int unsigned C0_ET   = 4;
  localparam int unsigned C0_PG   = 31;
  localparam int unsigned C4_PSE  = 4;
  localparam int unsigned C4_PAE  = 5;
  localparam int unsigned C4_PGE  = 7;
  localparam int unsigned FT_LME  = 8;
  localparam int unsigned AT_DPL  = 5;
  localparam int unsigned AT_LONG = 9;
  localparam int unsigned FL_VM   = 17;
endpackage

// File: rtl/mt_ctl_regs.sv
module mt_ctl_regs
  import mt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [3:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctl0_q,
  output logic          lma_q,
  output logic          vm_q,
  output logic          flush_all_q,
  output logic          flush_ng_q
);
  localparam logic [DW-1:0] ET_MASK = DW'(1) << C0_ET;
  localparam logic [DW-1:0] C4_MASK = (DW'(1) << C4_PSE) | (DW'(1) << C4_PAE) |
                                      (DW'(1) << C4_PGE);

  logic [DW-1:0] ctl4_q;
  logic          lme_q;
  logic          is_ctl0, is_ctl3, is_ctl4, is_feat, is_flags;
  logic          pg_flip, c4_flip;

  always_comb begin
    is_ctl0  = wr_fire && (wr_sel == SEL_CTL0);
    is_ctl3  = wr_fire && (wr_sel == SEL_CTL3);
    is_ctl4  = wr_fire && (wr_sel == SEL_CTL4);
    is_feat  = wr_fire && (wr_sel == SEL_FEAT);
    is_flags = wr_fire && (wr_sel == SEL_FLAGS);
    pg_flip  = is_ctl0 && (ctl0_q[C0_PG] != wr_data[C0_PG]);
    c4_flip  = is_ctl4 && (|((ctl4_q ^ wr_data) & C4_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q      <= ET_MASK;
      ctl4_q      <= '0;
      lme_q       <= 1'b0;
      lma_q       <= 1'b0;
      vm_q        <= 1'b0;
      flush_all_q <= 1'b0;
      flush_ng_q  <= 1'b0;
    end else begin
      if (is_ctl0) begin
        ctl0_q <= wr_data | ET_MASK;
        if (pg_flip && lme_q) lma_q <= wr_data[C0_PG];
      end
      if (is_ctl4)  ctl4_q <= wr_data;
      if (is_feat)  lme_q  <= wr_data[FT_LME];
      if (is_flags) vm_q   <= wr_data[FL_VM];
      flush_all_q <= pg_flip || c4_flip;
      flush_ng_q  <= is_ctl3;
    end
  end

  a_r2_et_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_sel == SEL_CTL0) |=> ctl0_q[C0_ET]);
  a_r6_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_q |-> $past(wr_fire && (wr_sel == SEL_CTL0 || wr_sel == SEL_CTL4)));
  a_r7_ng_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ng_q |-> $past(wr_fire && wr_sel == SEL_CTL3));
  a_r3_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lma_q) |-> ($past(lme_q) && flush_all_q));
endmodule

// File: rtl/mt_seg_bases.sv
module mt_seg_bases
  import mt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic [3:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic               lma,
  output logic               cs_long_q,
  output logic [1:0]         dpl_q,
  output logic [NSEG*AW-1:0] eff_flat
);
  logic is_attr, long_new, long_flip, in64;

  always_comb begin
    is_attr   = wr_fire && (wr_sel == SEL_CSATR);
    long_new  = wr_data[AT_LONG];
    long_flip = is_attr && (long_new != cs_long_q);
    in64      = lma && cs_long_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_long_q <= 1'b0;
      dpl_q     <= 2'd0;
    end else if (is_attr) begin
      cs_long_q <= long_new;
      dpl_q     <= wr_data[AT_DPL +: 2];
    end
  end

  a_r11_cpl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_sel == SEL_CSATR) |=> dpl_q == $past(wr_data[AT_DPL +: 2]));

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [3:0] MY_SEL = 4'(int'(SEL_ES) + g);
    logic [AW-1:0] base_q, eff_q;
    logic          hit;

    assign hit = wr_fire && (wr_sel == MY_SEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        eff_q  <= '0;
      end else if (hit) begin
        base_q <= wr_data[AW-1:0];
        if (!in64) eff_q <= wr_data[AW-1:0];
      end else if (long_flip) begin
        eff_q <= long_new ? '0 : base_q;
      end
    end

    assign eff_flat[g*AW +: AW] = eff_q;

    a_r10_eff_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && wr_sel == MY_SEL && lma && cs_long_q) |=> $stable(eff_q));
    a_r9_zero_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_long_q) |-> (eff_q == '0));
  end
endmodule

// File: rtl/mt_mode_decode.sv
module mt_mode_decode
  import mt_pkg::*;
(
  input  logic     lma,
  input  logic     cs_long,
  input  logic     pe,
  input  logic     vm,
  output submode_e sub
);
  always_comb begin
    if (lma)      sub = cs_long ? SM_64 : SM_COMPAT;
    else if (!pe) sub = SM_REAL;
    else          sub = vm ? SM_V86 : SM_PROT;
  end
endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
  import mt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [3:0]                 wr_sel,
  input  logic [DW-1:0]              wr_data,
  output logic                       mode_long,
  output logic [2:0]                 submode,
  output logic [1:0]                 cpl,
  output logic [DW-1:0]              ctl0_value,
  output logic [mt_pkg::NSEG*AW-1:0] eff_base,
  output logic                       flush_all,
  output logic                       flush_nonglobal
);
  logic     wr_fire, lma, vm, cs_long;
  submode_e sub;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  mt_ctl_regs #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctl0_q(ctl0_value), .lma_q(lma), .vm_q(vm),
    .flush_all_q(flush_all), .flush_ng_q(flush_nonglobal)
  );

  mt_seg_bases #(.DW(DW), .AW(AW)) u_seg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_sel(wr_sel),
    .wr_data(wr_data), .lma(lma), .cs_long_q(cs_long), .dpl_q(cpl),
    .eff_flat(eff_base)
  );

  mt_mode_decode u_dec (
    .lma(lma), .cs_long(cs_long), .pe(ctl0_value[C0_PE]), .vm(vm), .sub(sub)
  );

  assign mode_long = lma;
  assign submode   = sub;

  a_r4_long_submode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_long |-> (submode == SM_64 || submode == SM_COMPAT));
  a_r5_legacy_submode: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_long |-> (submode == SM_REAL || submode == SM_PROT || submode == SM_V86));
  a_r12_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_sel > 4'd9) |=> ($stable(ctl0_value) && $stable(eff_base) &&
                                    $stable(cpl) && $stable(mode_long)));
endmodule

// File: tb/mode_tracker_tb.sv
`timescale 1ns/1ps
module mode_tracker_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [3:0]   wr_sel = '0;
  logic [31:0]  wr_data = '0;
  logic         mode_long;
  logic [2:0]   submode;
  logic [1:0]   cpl;
  logic [31:0]  ctl0_value;
  logic [127:0] eff_base;
  logic         flush_all, flush_nonglobal;

  always #2 clk = ~clk;

  mode_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .mode_long(mode_long),
    .submode(submode), .cpl(cpl), .ctl0_value(ctl0_value),
    .eff_base(eff_base), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal)
  );

  typedef struct {
    logic         fa, fng, lng;
    logic [2:0]   sm;
    logic [1:0]   cp;
    logic [31:0]  c0;
    logic [127:0] eff;
    string        req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;

  // reference state
  logic [31:0] m_c0 = 32'h10, m_c4 = '0;
  logic        m_lme = 0, m_lma = 0, m_vm = 0, m_csl = 0;
  logic [1:0]  m_dpl = 0;
  logic [31:0] m_base[4] = '{default: '0};
  logic [31:0] m_eff[4]  = '{default: '0};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [2:0] m_sub();
    if (m_lma) return m_csl ? 3'd4 : 3'd3;
    if (!m_c0[0]) return 3'd0;
    return m_vm ? 3'd2 : 3'd1;
  endfunction

  // driver: one cycle of stimulus plus the expected outcome
  task automatic step(input logic v, input logic [3:0] s, input logic [31:0] d,
                      input string req);
    exp_t e;
    wr_valid = v; wr_sel = s; wr_data = d;
    e.fa  = v && ((s == 0 && (m_c0[31] != d[31])) ||
                  (s == 2 && |((m_c4 ^ d) & 32'hB0)));
    e.fng = v && (s == 1);
    if (v) begin
      case (s)
        4'd0: begin
          if ((m_c0[31] != d[31]) && m_lme) m_lma = d[31];
          m_c0 = d | 32'h10;
        end
        4'd2: m_c4 = d;
        4'd3: m_lme = d[8];
        4'd4: begin
          if (d[9] != m_csl)
            for (int i = 0; i < 4; i++) m_eff[i] = d[9] ? 32'h0 : m_base[i];
          m_csl = d[9];
          m_dpl = d[6:5];
        end
        4'd5: m_vm = d[17];
        4'd6, 4'd7, 4'd8, 4'd9: begin
          if (!(m_lma && m_csl)) m_eff[s-6] = d;
          m_base[s-6] = d;
        end
        default: ;
      endcase
    end
    e.lng = m_lma; e.sm = m_sub(); e.cp = m_dpl; e.c0 = m_c0;
    e.eff = {m_eff[3], m_eff[2], m_eff[1], m_eff[0]};
    e.req = req;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compares after each edge once registers have settled
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(flush_all == e.fa, e.req, "flush_all", 128'(flush_all), 128'(e.fa));
      chk(flush_nonglobal == e.fng, e.req, "flush_nonglobal",
          128'(flush_nonglobal), 128'(e.fng));
      chk(mode_long == e.lng, e.req, "mode_long", 128'(mode_long), 128'(e.lng));
      chk(submode == e.sm, e.req, "submode", 128'(submode), 128'(e.sm));
      chk(cpl == e.cp, e.req, "cpl", 128'(cpl), 128'(e.cp));
      chk(ctl0_value == e.c0, e.req, "ctl0_value", 128'(ctl0_value), 128'(e.c0));
      chk(eff_base == e.eff, e.req, "eff_base", eff_base, e.eff);
      chk(wr_ready == 1'b1, "R13", "wr_ready", 128'(wr_ready), 128'(1));
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");                       // reset state
    step(1, 0, 32'h0000_0000, "R2");           // ET forced
    step(1, 0, 32'h0000_0001, "R5");           // protected
    step(1, 5, 32'h0002_0000, "R5");           // virtual-8086
    step(1, 5, 32'h0000_0000, "R5");           // back to protected
    step(1, 1, 32'h1234_5000, "R7");           // non-global flush
    step(0, 0, 0, "R7");                       // pulse drops
    step(1, 2, 32'h0000_0020, "R8");           // PAE flip
    step(1, 2, 32'h0000_0021, "R8");           // other bit only
    step(1, 2, 32'h0000_00A1, "R8");           // PGE flip
    step(1, 0, 32'h8000_0001, "R3");           // paging on, LME clear
    step(0, 0, 0, "R6");                       // single-cycle pulse
    step(1, 0, 32'h8000_0001, "R6");           // no flip, no flush
    step(1, 0, 32'h0000_0001, "R6");           // paging off
    step(1, 3, 32'h0000_0400, "R12");          // LMA bit in data ignored
    step(1, 12, 32'hFFFF_FFFF, "R12");         // unused select
    step(1, 3, 32'h0000_0100, "R12");          // LME on
    step(1, 6, 32'h1111_0000, "R10");
    step(1, 7, 32'h2222_0000, "R10");
    step(1, 8, 32'h3333_0000, "R10");
    step(1, 9, 32'h4444_0000, "R10");
    step(1, 0, 32'h8000_0001, "R3");           // long mode, compatibility
    step(1, 4, 32'h0000_0260, "R9");           // long bit on, DPL 3
    step(0, 0, 0, "R11");
    step(1, 6, 32'h5555_0000, "R10");          // frozen in 64-bit
    step(1, 4, 32'h0000_0020, "R9");           // long bit off, restore
    step(1, 4, 32'h0000_0240, "R4");           // 64-bit again, DPL 2
    step(1, 0, 32'h0000_0001, "R3");           // leave long mode
    step(1, 8, 32'h6666_0000, "R10");          // legacy, cs long set
    step(1, 0, 32'h8000_0000, "R4");           // long, 64-bit, PE clear
    step(1, 4, 32'h0000_0000, "R4");           // compatibility, restore
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R1");
    finish_run();
  end
endmodule